// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter

A 16-bit counter with a companion 16-bit capture/reload register, set up through a small byte-wide register bus. Control bits select the job of the counter. It can latch its running value when an external trigger pin falls. It can reload automatically while counting up. It can count up or down, with the trigger pin level giving the direction. It can act as a baud-rate source for a serial transmitter and receiver. It can also drive a square wave with a 50% duty cycle.

The counter advances on one of two count sources. The first is a tick from an internal prescaler that divides the system clock by `PRE_DIV`. The second is a falling edge on an external count pin. Both external pins pass through a two-flop synchroniser before any edge detection. Two sticky flags report counter overflow and trigger-pin events. They stay set until software writes 0 to them.

Register map (3-bit address): 0 = control, 1 = mode, 2/3 = count low/high byte, 4/5 = reload/capture low/high byte, 6/7 = read 00h. Control bits: [0] run, [1] count source (1 = external pin falls), [2] capture mode, [3] trigger enable, [4] transmit baud select, [5] receive baud select, [6] overflow flag, [7] trigger flag. Mode bits: [0] up/down enable, [1] clock-out enable, [7:2] unimplemented.

Top module: `tmr16_multi`

## Requirements
- R1: After reset every register reads 00h. The mode register reads only bits [1:0]: writing FFh reads back 03h.
- R2: In reload mode with up/down disabled, a count tick at FFFFh loads the reload value and sets the overflow flag (control bit 6).
- R3: In reload mode with up/down disabled and the trigger enable set, a synchronised falling edge on the trigger pin loads the reload value into the count and sets the trigger flag (control bit 7). With the trigger enable clear, the edge has no effect.
- R4: In capture mode, a trigger-pin falling edge with the trigger enable set copies the count into the reload/capture register and sets the trigger flag. A tick at FFFFh wraps the count to 0000h and sets the overflow flag.
- R5: With mode bit 0 set, a high synchronised trigger level counts up and a low level counts down. Counting down at a count equal to the reload value loads FFFFh and sets the overflow flag.
- R6: With either baud select bit set, an overflow reloads the count without setting the overflow flag. It gives a one-cycle pulse on `tx_tick_o` and/or `rx_tick_o`, matching the select bits, in the cycle the reload value appears.
- R7: With mode bit 1 set, `clk_out_o` toggles on each overflow and the overflow flag is not set. With the bit clear, `clk_out_o` is low.
- R8: With run set and source 0, the count advances once every `PRE_DIV` clocks. With source 1, it advances once per falling edge of `cnt_pin_i`, and the count changes on the third rising clock edge after the pin falls.
- R9: Both flags stay set until a control write puts a 0 there. A hardware set in the same cycle as such a write wins.
- R10: A bus write to a count byte takes priority over counting and trigger reloads in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| cnt_pin_i | input | 1 | External count pin, falling edges counted |
| trig_pin_i | input | 1 | External trigger / direction pin |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ext_flag_o | output | 1 | Sticky trigger-event flag |
| tx_tick_o | output | 1 | Baud tick for the transmit path |
| rx_tick_o | output | 1 | Baud tick for the receive path |
| clk_out_o | output | 1 | 50% duty-cycle clock output |

## Verification
The bench drives the hard boundaries and compares every output against a behavioural model on every clock:
- Overflow from FFFFh in each mode. A design that wrapped to zero in reload mode, or set the overflow flag in baud mode, would diverge at once.
- The down-count wrap when the count equals the reload value. An off-by-one compare shows up as a wrong count one tick later.
- Trigger edges with the enable both set and clear. A wrongly enabled reload or capture changes the count or capture register that the bench reads back.
- Flag clears that land on the same cycle as a hardware set. A design where the write wins would drop a flag that the model keeps.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int unsigned AW    = 3;
  localparam int unsigned CNT_W = 16;

  localparam logic [AW-1:0] A_CTRL  = 3'd0;
  localparam logic [AW-1:0] A_MODE  = 3'd1;
  localparam logic [AW-1:0] A_CNT_L = 3'd2;
  localparam logic [AW-1:0] A_CNT_H = 3'd3;
  localparam logic [AW-1:0] A_RLD_L = 3'd4;
  localparam logic [AW-1:0] A_RLD_H = 3'd5;

  localparam int unsigned OVF_BIT = 6;
  localparam int unsigned EXT_BIT = 7;

  typedef struct packed {
    logic rx_sel;
    logic tx_sel;
    logic ext_en;
    logic cap_mode;
    logic src_ext;
    logic run;
  } ctrl_t;

  typedef struct packed {
    logic clk_out_en;
    logic dir_en;
  } mode_t;
endpackage

// File: rtl/tmr16_sync.sv
module tmr16_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic lvl_d_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign lvl_o   = sh_q[STAGES-1];
  assign lvl_d_o = sh_q[STAGES];
endmodule

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            pre_q <= '0;
    else if (!run_i)        pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                    pre_q <= pre_q + 1'b1;
  end

  assign tick_o = run_i && (pre_q == LAST);
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             tick_i,
  input  logic             trig_fall_i,
  input  logic             trig_lvl_i,
  input  logic             cap_mode_i,
  input  logic             ext_en_i,
  input  logic             tx_sel_i,
  input  logic             rx_sel_i,
  input  logic             dir_en_i,
  input  logic             clk_out_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             ovf_o,
  output logic             ext_o,
  output logic             tx_tick_o,
  output logic             rx_tick_o,
  output logic             clk_out_o
);
  localparam int unsigned NB = CNT_W / 8;
  localparam logic [CNT_W-1:0] ALL1 = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d, cnt_wdat, rld_wdat;
  logic             ovf_q, ext_q, tx_q, rx_q, clk_out_q;
  logic             gen_mode, cap_act, ud_act, rl_act;
  logic             ext_evt, ext_rl, cnt_wr, rld_wr, ctrl_wr;
  logic             cnt_max, count_dn, wrap, gen_wrap;

  always_comb begin
    gen_mode = tx_sel_i || rx_sel_i || clk_out_en_i;
    cap_act  = !gen_mode && cap_mode_i;
    ud_act   = !gen_mode && !cap_mode_i && dir_en_i;
    rl_act   = !gen_mode && !cap_mode_i && !dir_en_i;
    ext_evt  = ext_en_i && trig_fall_i && !ud_act;
    ext_rl   = ext_evt && rl_act;
    ctrl_wr  = wr_i && (addr_i == A_CTRL);
  end

  // byte-lane write data
  always_comb begin
    cnt_wdat = cnt_q;
    rld_wdat = rld_q;
    cnt_wr   = 1'b0;
    rld_wr   = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (wr_i && addr_i == AW'(A_CNT_L + b)) begin
        cnt_wdat[b*8 +: 8] = wdata_i;
        cnt_wr = 1'b1;
      end
      if (wr_i && addr_i == AW'(A_RLD_L + b)) begin
        rld_wdat[b*8 +: 8] = wdata_i;
        rld_wr = 1'b1;
      end
    end
  end

  always_comb begin
    cnt_max  = (cnt_q == ALL1);
    count_dn = ud_act && !trig_lvl_i;
    wrap     = tick_i && !cnt_wr && !ext_rl &&
               (count_dn ? (cnt_q == rld_q) : cnt_max);
    gen_wrap = wrap && gen_mode;

    cnt_d = cnt_q;
    if (cnt_wr)      cnt_d = cnt_wdat;
    else if (ext_rl) cnt_d = rld_q;
    else if (tick_i) begin
      if (count_dn)     cnt_d = wrap ? ALL1 : cnt_q - 1'b1;
      else if (cnt_max) cnt_d = cap_act ? '0 : rld_q;
      else              cnt_d = cnt_q + 1'b1;
    end

    rld_d = rld_q;
    if (rld_wr)                  rld_d = rld_wdat;
    else if (ext_evt && cap_act) rld_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      rld_q     <= '0;
      ovf_q     <= 1'b0;
      ext_q     <= 1'b0;
      tx_q      <= 1'b0;
      rx_q      <= 1'b0;
      clk_out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
      // hardware set wins over a same-cycle clear
      ovf_q <= (ctrl_wr ? wdata_i[OVF_BIT] : ovf_q) | (wrap && !gen_mode);
      ext_q <= (ctrl_wr ? wdata_i[EXT_BIT] : ext_q) | ext_evt;
      tx_q  <= gen_wrap && tx_sel_i;
      rx_q  <= gen_wrap && rx_sel_i;
      if (!clk_out_en_i) clk_out_q <= 1'b0;
      else if (gen_wrap) clk_out_q <= ~clk_out_q;
    end
  end

  assign cnt_o     = cnt_q;
  assign rld_o     = rld_q;
  assign ovf_o     = ovf_q;
  assign ext_o     = ext_q;
  assign tx_tick_o = tx_q;
  assign rx_tick_o = rx_q;
  assign clk_out_o = clk_out_q;

  // R2
  reload_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rl_act && tick_i && cnt_max && !cnt_wr && !ext_evt)
      |=> (ovf_q && cnt_q == $past(rld_q)));

  // R4
  capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_act && ext_evt && !rld_wr) |=> (ext_q && rld_q == $past(cnt_q)));

  // R5
  down_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ud_act && !trig_lvl_i && tick_i && !cnt_wr && cnt_q == rld_q)
      |=> (ovf_q && cnt_q == ALL1));

  // R6
  baud_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gen_mode && tick_i && cnt_max && !cnt_wr && !ctrl_wr)
      |=> (cnt_q == $past(rld_q) && ovf_q == $past(ovf_q)));

  // R7
  clk_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_out_q) |-> ($past(gen_wrap) || !$past(clk_out_en_i)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_q) |-> $past(ctrl_wr));
endmodule

// File: rtl/tmr16_multi.sv
module tmr16_multi
  import tmr16_pkg::*;
#(
  parameter int unsigned PRE_DIV   = 4,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o,
  input  logic          cnt_pin_i,
  input  logic          trig_pin_i,
  output logic          ovf_flag_o,
  output logic          ext_flag_o,
  output logic          tx_tick_o,
  output logic          rx_tick_o,
  output logic          clk_out_o
);
  localparam int unsigned NPIN = 2;

  ctrl_t            ctrl_q;
  mode_t            mode_q;
  logic [NPIN-1:0]  pins, lvl, lvl_d, fall;
  logic             pre_tick, tick;
  logic [CNT_W-1:0] cnt, rld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_CTRL) ctrl_q <= ctrl_t'(wdata_i[$bits(ctrl_t)-1:0]);
      if (addr_i == A_MODE) mode_q <= mode_t'(wdata_i[$bits(mode_t)-1:0]);
    end
  end

  // pin 0: count source, pin 1: trigger / direction
  assign pins = {trig_pin_i, cnt_pin_i};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    tmr16_sync #(.STAGES(SYNC_STGS)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins[g]),
      .lvl_o  (lvl[g]),
      .lvl_d_o(lvl_d[g])
    );
    assign fall[g] = lvl_d[g] & ~lvl[g];
  end

  tmr16_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (ctrl_q.run),
    .tick_o(pre_tick)
  );

  assign tick = ctrl_q.run && (ctrl_q.src_ext ? fall[0] : pre_tick);

  tmr16_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .tick_i      (tick),
    .trig_fall_i (fall[1]),
    .trig_lvl_i  (lvl[1]),
    .cap_mode_i  (ctrl_q.cap_mode),
    .ext_en_i    (ctrl_q.ext_en),
    .tx_sel_i    (ctrl_q.tx_sel),
    .rx_sel_i    (ctrl_q.rx_sel),
    .dir_en_i    (mode_q.dir_en),
    .clk_out_en_i(mode_q.clk_out_en),
    .cnt_o       (cnt),
    .rld_o       (rld),
    .ovf_o       (ovf_flag_o),
    .ext_o       (ext_flag_o),
    .tx_tick_o   (tx_tick_o),
    .rx_tick_o   (rx_tick_o),
    .clk_out_o   (clk_out_o)
  );

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = {ext_flag_o, ovf_flag_o, ctrl_q};
      A_MODE:  rdata_o = {6'd0, mode_q};
      A_CNT_L: rdata_o = cnt[7:0];
      A_CNT_H: rdata_o = cnt[15:8];
      A_RLD_L: rdata_o = rld[7:0];
      A_RLD_H: rdata_o = rld[15:8];
      default: rdata_o = 8'd0;
    endcase
  end

  // R10
  cnt_write_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_CNT_L) |=> (cnt[7:0] == $past(wdata_i)));
endmodule

// File: tb/test_tmr16_multi.sv
module test_tmr16_multi;
  localparam int PRE = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       cnt_pin_i = 1'b1;
  logic       trig_pin_i = 1'b1;
  logic       ovf_flag_o, ext_flag_o, tx_tick_o, rx_tick_o, clk_out_o;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  tmr16_multi #(.PRE_DIV(PRE)) i_tmr16_multi (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .cnt_pin_i(cnt_pin_i),
    .trig_pin_i(trig_pin_i), .ovf_flag_o(ovf_flag_o), .ext_flag_o(ext_flag_o),
    .tx_tick_o(tx_tick_o), .rx_tick_o(rx_tick_o), .clk_out_o(clk_out_o)
  );

  // behavioural reference model
  logic [15:0] m_cnt, m_rld;
  logic [5:0]  m_ctrl;
  logic [1:0]  m_mode;
  logic        m_ovf, m_ext, m_tx, m_rx, m_clk;
  int          m_pre;
  logic [2:0]  m_ph, m_th;  // pin history, [0] newest

  always @(posedge clk_i or negedge rst_ni) begin : model
    logic run, src, cap, een, txs, rxs, dir, coe, gen, cap_a, ud_a, rl_a;
    logic pf, tf, tl, tick, ext_e, ext_rl, cwr, rwr, cw, dn, wrap;
    logic [15:0] nc, nr;
    if (!rst_ni) begin
      m_cnt = 0; m_rld = 0; m_ctrl = 0; m_mode = 0; m_ovf = 0; m_ext = 0;
      m_tx = 0; m_rx = 0; m_clk = 0; m_pre = 0; m_ph = 0; m_th = 0;
    end else begin
      run = m_ctrl[0]; src = m_ctrl[1]; cap = m_ctrl[2]; een = m_ctrl[3];
      txs = m_ctrl[4]; rxs = m_ctrl[5]; dir = m_mode[0]; coe = m_mode[1];
      gen = txs | rxs | coe;
      cap_a = !gen && cap; ud_a = !gen && !cap && dir; rl_a = !gen && !cap && !dir;
      pf = m_ph[2] & ~m_ph[1];
      tf = m_th[2] & ~m_th[1];
      tl = m_th[1];
      tick = run && (src ? pf : (m_pre == PRE - 1));
      cwr = wr_en_i && (addr_i == 2 || addr_i == 3);
      rwr = wr_en_i && (addr_i == 4 || addr_i == 5);
      cw  = wr_en_i && addr_i == 0;
      ext_e = een && tf && !ud_a;
      ext_rl = ext_e && rl_a;
      dn = ud_a && !tl;
      wrap = tick && !cwr && !ext_rl && (dn ? (m_cnt == m_rld) : (m_cnt == 16'hFFFF));
      nc = m_cnt;
      if (cwr) begin
        if (addr_i == 2) nc[7:0] = wdata_i; else nc[15:8] = wdata_i;
      end else if (ext_rl) nc = m_rld;
      else if (tick) begin
        if (dn) nc = wrap ? 16'hFFFF : m_cnt - 16'd1;
        else if (m_cnt == 16'hFFFF) nc = cap_a ? 16'h0000 : m_rld;
        else nc = m_cnt + 16'd1;
      end
      nr = m_rld;
      if (rwr) begin
        if (addr_i == 4) nr[7:0] = wdata_i; else nr[15:8] = wdata_i;
      end else if (ext_e && cap_a) nr = m_cnt;
      m_ovf = (cw ? wdata_i[6] : m_ovf) | (wrap && !gen);
      m_ext = (cw ? wdata_i[7] : m_ext) | ext_e;
      m_tx = wrap && gen && txs;
      m_rx = wrap && gen && rxs;
      m_clk = !coe ? 1'b0 : ((wrap && gen) ? ~m_clk : m_clk);
      m_pre = !run ? 0 : ((m_pre == PRE - 1) ? 0 : m_pre + 1);
      if (cw) m_ctrl = wdata_i[5:0];
      if (wr_en_i && addr_i == 1) m_mode = wdata_i[1:0];
      m_cnt = nc; m_rld = nr;
      m_ph = {m_ph[1:0], cnt_pin_i};
      m_th = {m_th[1:0], trig_pin_i};
    end
  end

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle output comparison
  always @(negedge clk_i) begin
    if (rst_ni) begin
      check(16'(ovf_flag_o), 16'(m_ovf), "R2 ovf flag");
      check(16'(ext_flag_o), 16'(m_ext), "R3 ext flag");
      check(16'(tx_tick_o), 16'(m_tx), "R6 tx tick");
      check(16'(rx_tick_o), 16'(m_rx), "R6 rx tick");
      check(16'(clk_out_o), 16'(m_clk), "R7 clk out");
    end
  end

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {m_ext, m_ovf, m_ctrl};
      3'd1: return {6'd0, m_mode};
      3'd2: return m_cnt[7:0];
      3'd3: return m_cnt[15:8];
      3'd4: return m_rld[7:0];
      3'd5: return m_rld[15:8];
      default: return 8'd0;
    endcase
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    wr(a, d[7:0]);
    wr(a + 3'd1, d[15:8]);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    @(negedge clk_i);
    addr_i = a;
    #1;
    check(16'(rdata_o), 16'(exp_rd(a)), tag);
  endtask

  task automatic rd_all(input string tag);
    for (int a = 0; a < 8; a++) rd(3'(a), tag);
  endtask

  task automatic trig_fall();
    @(negedge clk_i) trig_pin_i = 1'b0;
    idle(4);
    trig_pin_i = 1'b1;
    idle(4);
  endtask

  initial begin : watchdog
    #(10 * 150000);
    n_fail++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    idle(3);
    rst_ni = 1'b1;
    // R1 reset values and mode width
    rd_all("R1 reset");
    wr(3'd1, 8'hFF);
    @(negedge clk_i) addr_i = 3'd1; #1;
    check(16'(rdata_o), 16'h0003, "R1 mode upper bits");
    wr(3'd1, 8'h00);

    // R2 / R8 internal prescale, up-count reload
    wr16(3'd4, 16'hFFF0);
    wr16(3'd2, 16'hFFFC);
    wr(3'd0, 8'h01);
    idle(9);
    rd(3'd2, "R8 prescale count");
    idle(30);
    rd_all("R2 reload");
    // R9 clear while overflows keep coming
    wr16(3'd4, 16'hFFFF);
    wr16(3'd2, 16'hFFFF);
    for (int i = 0; i < 10; i++) wr(3'd0, 8'h01);
    rd(3'd0, "R9 flag clear race");
    // R10 count write wins over ticks
    for (int i = 0; i < 6; i++) wr(3'd2, 8'hA0);
    rd_all("R10 write priority");
    wr(3'd0, 8'h00);

    // R3 trigger reload, enabled then disabled
    wr16(3'd4, 16'h1234);
    wr16(3'd2, 16'h0100);
    wr(3'd0, 8'h09);
    idle(10);
    trig_fall();
    rd_all("R3 ext reload");
    wr(3'd0, 8'h01);
    idle(6);
    trig_fall();
    rd_all("R3 edge ignored");
    wr(3'd0, 8'h00);

    // R4 capture and wrap to zero
    wr16(3'd4, 16'h0000);
    wr16(3'd2, 16'hFFFD);
    wr(3'd0, 8'h0D);
    idle(30);
    trig_fall();
    rd_all("R4 capture");
    wr(3'd0, 8'h00);

    // R5 up/down
    wr(3'd1, 8'h01);
    wr16(3'd4, 16'h0010);
    wr16(3'd2, 16'h0013);
    trig_pin_i = 1'b0;
    idle(4);
    wr(3'd0, 8'h01);
    idle(24);
    rd_all("R5 down wrap");
    trig_pin_i = 1'b1;
    idle(12);
    rd_all("R5 up reload");
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);

    // R6 baud generation: tx, rx, both
    wr16(3'd4, 16'hFFFA);
    wr16(3'd2, 16'hFFF8);
    wr(3'd0, 8'h11);
    idle(40);
    wr(3'd0, 8'h21);
    idle(40);
    wr(3'd0, 8'h31);
    idle(40);
    rd_all("R6 baud");
    wr(3'd0, 8'h00);

    // R7 clock out
    wr(3'd1, 8'h02);
    wr16(3'd4, 16'hFFFE);
    wr16(3'd2, 16'hFFFE);
    wr(3'd0, 8'h01);
    idle(60);
    rd_all("R7 clkout");
    wr(3'd1, 8'h00);
    idle(2);
    check(16'(clk_out_o), 16'h0000, "R7 clkout low when off");
    wr(3'd0, 8'h00);

    // R8 external count source
    wr16(3'd2, 16'h0000);
    wr(3'd0, 8'h03);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i) cnt_pin_i = 1'b0;
      idle(3);
      cnt_pin_i = 1'b1;
      idle(3);
    end
    idle(4);
    rd(3'd2, "R8 ext count");
    @(negedge clk_i) addr_i = 3'd2; #1;
    check(16'(rdata_o), 16'h000A, "R8 ext count value");
    wr(3'd0, 8'h00);

    idle(5);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule